// File: doc/BRIEF.md
# Multi-mode stepped attenuation controller

This block produces the 6-bit attenuation code for one channel of a variable-gain amplifier. Code zero is maximum gain. Each code step adds 0.5 dB of attenuation, so the bit weights from LSB to MSB are 0.5, 1, 2, 4, 8 and 16 dB. A two-bit mode input selects where the code comes from. In parallel mode, a six-bit word is loaded through a transparent-or-hold control. In pulse mode, active-low up and down strobes move the code by one of four step sizes.

The up and down strobes are asynchronous to the block clock. Each one passes through a two-flop synchroniser and an edge detector, and only its falling edge acts. Step arithmetic saturates at both ends of the code range. A low on both strobes in the same sampled cycle resets the code to maximum gain. The enable input freezes the code in every mode. The reserved and unimplemented mode values also freeze the code, and they drop the valid flag.

Top module: `atten_ctrl`

## Requirements
- R1: A synchronous active-high reset sets atten_o to 0 and valid_o to 0, and it sets the strobe history to idle-high. The first clock after reset with both strobes high therefore causes no step.
- R2: In parallel mode (mode_i = 2'b11) with en_i = 1 and hold_i = 0, atten_o equals par_word_i sampled at the previous rising edge.
- R3: In parallel mode, while hold_i = 1, atten_o keeps its value and ignores par_word_i.
- R4: In pulse mode (mode_i = 2'b01), a falling edge on dn_n_i increases atten_o by the selected step. This lowers the gain.
- R5: In pulse mode, a falling edge on up_n_i decreases atten_o by the selected step. This raises the gain.
- R6: The step size is chosen by step_sel_i, where bit 1 carries S0 and bit 0 carries S1. The value 2'b00 gives a code delta of 1 (0.5 dB), 2'b01 gives 2 (1 dB), 2'b10 gives 4 (2 dB) and 2'b11 gives 12 (6 dB).
- R7: Step arithmetic saturates. A down step that would pass 63 yields 63, and an up step that would pass below 0 yields 0.
- R8: When both strobes are sampled low in the same cycle as a falling edge on either strobe, atten_o becomes 0.
- R9: A strobe held low produces exactly one step. Rising edges produce none.
- R10: While en_i = 0, atten_o holds its value in every mode, and strobe edges and parallel words are ignored.
- R11: When mode_i is 2'b00 (reserved) or 2'b10 (serial, not implemented), atten_o holds its value and valid_o is 0 one cycle later. When mode_i is 2'b11 or 2'b01, valid_o is 1 one cycle later.
- R12: A strobe that falls before rising edge k changes atten_o at rising edge k+2. Edges k and k+1 shift it through the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | Source select: 11 parallel, 01 pulse, 10 serial (unsupported), 00 reserved |
| en_i | input | 1 | Channel enable, active high |
| par_word_i | input | 6 | Parallel attenuation word |
| hold_i | input | 1 | Parallel hold: 0 transparent, 1 hold |
| up_n_i | input | 1 | Active-low gain-up strobe, asynchronous |
| dn_n_i | input | 1 | Active-low gain-down strobe, asynchronous |
| step_sel_i | input | 2 | Pulse step size: bit 1 is S0, bit 0 is S1 |
| atten_o | output | 6 | Registered attenuation code, 0 = maximum gain |
| valid_o | output | 1 | Registered flag, high while a supported mode is selected |

## Verification
The bound checker watches these behaviours on every cycle:
- the reset state;
- parallel-mode tracking;
- stability under hold, under a low enable and under the unsupported mode values;
- the valid flag.

The pulse path needs the bench's scenarios. Its step sizes, the saturation at both ends, the simultaneous-strobe reset, the single step per held strobe and the exact two-cycle synchroniser delay depend on history that the scenarios build up step by step.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int CODE_W      = 6;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        MODE_RSVD   = 2'b00,
        MODE_PULSE  = 2'b01,
        MODE_SERIAL = 2'b10,
        MODE_PAR    = 2'b11
    } mode_e;

    typedef struct packed {
        logic up_fall;
        logic dn_fall;
        logic both_low;
    } strobe_ev_t;

    // step_sel bit 1 = S0, bit 0 = S1
    function automatic logic [CODE_W-1:0] step_delta(input logic [1:0] sel);
        logic [CODE_W-1:0] d;
        unique case (sel)
            2'b00:   d = CODE_W'(1);
            2'b01:   d = CODE_W'(2);
            2'b10:   d = CODE_W'(4);
            default: d = CODE_W'(12);
        endcase
        return d;
    endfunction

    function automatic logic mode_supported(input mode_e m);
        return (m == MODE_PAR) || (m == MODE_PULSE);
    endfunction

endpackage

// File: rtl/atten_strobe_sync.sv
module atten_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  up_n_i,
    input  logic                  dn_n_i,
    output atten_pkg::strobe_ev_t ev_o
);
    localparam int LAST = STAGES - 1;

    logic [1:0] raw;
    logic [1:0] stage_q [STAGES];
    logic [1:0] prev_q;
    logic [1:0] cur;

    assign raw = {up_n_i, dn_n_i};

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= 2'b11;
                    else     stage_q[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= 2'b11;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign cur = stage_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b11;
        else     prev_q <= cur;
    end

    always_comb begin
        ev_o.up_fall  = prev_q[1] & ~cur[1];
        ev_o.dn_fall  = prev_q[0] & ~cur[0];
        ev_o.both_low = ~cur[1] & ~cur[0];
    end

endmodule

// File: rtl/atten_step_calc.sv
module atten_step_calc #(
    parameter int W        = 6,
    parameter bit DIR_DOWN = 1'b1
) (
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] delta_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

    generate
        if (DIR_DOWN) begin : g_add
            logic [W:0] sum;
            always_comb begin
                sum    = {1'b0, code_i} + {1'b0, delta_i};
                code_o = sum[W] ? CODE_MAX : sum[W-1:0];
            end
        end else begin : g_sub
            always_comb begin
                code_o = (delta_i > code_i) ? '0 : (code_i - delta_i);
            end
        end
    endgenerate

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl #(
    parameter int CODE_W      = atten_pkg::CODE_W,
    parameter int SYNC_STAGES = atten_pkg::SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] par_word_i,
    input  logic              hold_i,
    input  logic              up_n_i,
    input  logic              dn_n_i,
    input  logic [1:0]        step_sel_i,
    output logic [CODE_W-1:0] atten_o,
    output logic              valid_o
);
    import atten_pkg::*;

    mode_e             mode;
    strobe_ev_t        ev;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CODE_W-1:0] delta;
    logic [CODE_W-1:0] code_dn, code_up;
    logic              valid_q;

    assign mode  = mode_e'(mode_i);
    assign delta = CODE_W'(step_delta(step_sel_i));

    atten_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .up_n_i (up_n_i),
        .dn_n_i (dn_n_i),
        .ev_o   (ev)
    );

    atten_step_calc #(.W(CODE_W), .DIR_DOWN(1'b1)) u_step_dn (
        .code_i  (code_q),
        .delta_i (delta),
        .code_o  (code_dn)
    );

    atten_step_calc #(.W(CODE_W), .DIR_DOWN(1'b0)) u_step_up (
        .code_i  (code_q),
        .delta_i (delta),
        .code_o  (code_up)
    );

    always_comb begin
        code_d = code_q;
        unique case (mode)
            MODE_PAR: begin
                if (en_i && !hold_i) code_d = par_word_i;
            end
            MODE_PULSE: begin
                if (en_i) begin
                    if ((ev.up_fall || ev.dn_fall) && ev.both_low) code_d = '0;
                    else if (ev.dn_fall)                           code_d = code_dn;
                    else if (ev.up_fall)                           code_d = code_up;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            code_q  <= code_d;
            valid_q <= mode_supported(mode);
        end
    end

    assign atten_o = code_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_i,
    input logic              en_i,
    input logic [CODE_W-1:0] par_word_i,
    input logic              hold_i,
    input logic [CODE_W-1:0] atten_o,
    input logic              valid_o
);
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (atten_o == '0 && !valid_o)); // R1

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11 && en_i && !hold_i) |=> (atten_o == $past(par_word_i))); // R2

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11 && hold_i) |=> $stable(atten_o)); // R3

    AST_DISABLED_STABLE: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> $stable(atten_o)); // R10

    AST_UNSUPPORTED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00 || mode_i == 2'b10) |=> $stable(atten_o)); // R11

    AST_VALID_FLAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (valid_o == ($past(mode_i) == 2'b11 || $past(mode_i) == 2'b01))); // R11

endmodule

bind atten_ctrl atten_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .en_i       (en_i),
    .par_word_i (par_word_i),
    .hold_i     (hold_i),
    .atten_o    (atten_o),
    .valid_o    (valid_o)
);

// File: tb/atten_ctrl_tb_top.sv
module atten_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode_i;
    logic       en_i;
    logic [5:0] par_word_i;
    logic       hold_i;
    logic       up_n_i;
    logic       dn_n_i;
    logic [1:0] step_sel_i;
    logic [5:0] atten_o;
    logic       valid_o;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    atten_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .en_i       (en_i),
        .par_word_i (par_word_i),
        .hold_i     (hold_i),
        .up_n_i     (up_n_i),
        .dn_n_i     (dn_n_i),
        .step_sel_i (step_sel_i),
        .atten_o    (atten_o),
        .valid_o    (valid_o)
    );

    // parallel-mode vectors: {hold, word[5:0], expected[5:0]}
    localparam int NPAR = 8;
    localparam logic [12:0] PAR_TAB [NPAR] = '{
        {1'b0, 6'd5,  6'd5},
        {1'b0, 6'd63, 6'd63},
        {1'b1, 6'd10, 6'd63},
        {1'b1, 6'd0,  6'd63},
        {1'b0, 6'd0,  6'd0},
        {1'b0, 6'd42, 6'd42},
        {1'b1, 6'd7,  6'd42},
        {1'b0, 6'd7,  6'd7}
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // drive strobes low, wait for the step, check, then release
    task automatic strobe(input logic up, input logic dn, input logic [1:0] sel,
                          input string req, input logic [5:0] exp);
        step_sel_i = sel;
        up_n_i = ~up;
        dn_n_i = ~dn;
        tick(3);
        check(req, atten_o, exp);
        up_n_i = 1'b1;
        dn_n_i = 1'b1;
        tick(3);
        check({req, " release"}, atten_o, exp);
    endtask

    initial begin
        rst = 1'b1; mode_i = 2'b11; en_i = 1'b1; par_word_i = 6'd33;
        hold_i = 1'b0; up_n_i = 1'b1; dn_n_i = 1'b1; step_sel_i = 2'b00;
        tick(3);
        check("R1 reset code", atten_o, 6'd0);
        check("R1 reset valid", {5'd0, valid_o}, 6'd0);
        rst = 1'b0;
        tick(1);
        check("R11 valid parallel", {5'd0, valid_o}, 6'd1);

        // parallel table
        for (int i = 0; i < NPAR; i++) begin
            hold_i     = PAR_TAB[i][12];
            par_word_i = PAR_TAB[i][11:6];
            tick(1);
            check(PAR_TAB[i][12] ? "R3 hold" : "R2 follow", atten_o, PAR_TAB[i][5:0]);
        end

        // R10 parallel with enable low
        en_i = 1'b0; par_word_i = 6'd50;
        tick(2);
        check("R10 parallel disabled", atten_o, 6'd7);
        en_i = 1'b1;
        tick(1);
        check("R2 re-enabled", atten_o, 6'd50);
        par_word_i = 6'd7;
        tick(1);

        // pulse mode, start at 7
        mode_i = 2'b01; par_word_i = 6'd30;
        tick(1);
        check("R11 valid pulse", {5'd0, valid_o}, 6'd1);
        check("R2 word ignored in pulse mode", atten_o, 6'd7);

        // R12 latency
        dn_n_i = 1'b0; step_sel_i = 2'b00;
        tick(2);
        check("R12 no change after two edges", atten_o, 6'd7);
        tick(1);
        check("R12 change at third edge", atten_o, 6'd8);
        tick(5);
        check("R9 held low single step", atten_o, 6'd8);
        dn_n_i = 1'b1;
        tick(3);
        check("R9 rising edge no step", atten_o, 6'd8);

        strobe(1'b0, 1'b1, 2'b01, "R4 R6 down by 2",  6'd10);
        strobe(1'b0, 1'b1, 2'b10, "R4 R6 down by 4",  6'd14);
        strobe(1'b0, 1'b1, 2'b11, "R4 R6 down by 12", 6'd26);
        strobe(1'b1, 1'b0, 2'b11, "R5 up by 12",      6'd14);
        strobe(1'b1, 1'b0, 2'b10, "R5 up by 4",       6'd10);
        strobe(1'b1, 1'b0, 2'b11, "R7 up clamps 0",   6'd0);
        strobe(1'b1, 1'b0, 2'b00, "R7 up at 0",       6'd0);
        for (int k = 1; k <= 5; k++)
            strobe(1'b0, 1'b1, 2'b11, "R4 ramp", 6'(12 * k));
        strobe(1'b0, 1'b1, 2'b11, "R7 down clamps 63", 6'd63);
        strobe(1'b0, 1'b1, 2'b00, "R7 down at 63",     6'd63);
        strobe(1'b1, 1'b1, 2'b00, "R8 both reset",     6'd0);
        strobe(1'b0, 1'b1, 2'b01, "R4 after reset",    6'd2);

        // R10 pulses ignored while disabled
        en_i = 1'b0;
        strobe(1'b0, 1'b1, 2'b11, "R10 pulse disabled", 6'd2);
        en_i = 1'b1;
        tick(1);
        check("R10 no late step", atten_o, 6'd2);

        // R11 unsupported modes
        mode_i = 2'b00; par_word_i = 6'd44; dn_n_i = 1'b0;
        tick(1);
        check("R11 reserved valid low", {5'd0, valid_o}, 6'd0);
        tick(3);
        check("R11 reserved holds", atten_o, 6'd2);
        dn_n_i = 1'b1;
        mode_i = 2'b10;
        tick(3);
        check("R11 serial valid low", {5'd0, valid_o}, 6'd0);
        check("R11 serial holds", atten_o, 6'd2);

        // R1 mid-run reset, then no spurious step
        mode_i = 2'b01; up_n_i = 1'b0;
        tick(1);
        rst = 1'b1;
        tick(1);
        check("R1 mid reset code", atten_o, 6'd0);
        up_n_i = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(4);
        check("R1 no step after reset", atten_o, 6'd0);
        check("R11 valid after reset", {5'd0, valid_o}, 6'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule